// File: doc/BRIEF.md
# Character-Row Cell Display Address Generator

This block scans a low-resolution cell display and produces one memory address per cell time. The picture is a grid of rows, each a fixed number of cells wide. Every fetched byte stands for one cell, and it stays on screen for all the scanlines of its row. For that reason the block repeats the same run of addresses on every scanline of a row. It moves to the next run only after the last scanline of that row.

Addresses are confined to a 1 KB window. The window is chosen by the upper bits of a programmed start address. The low ten bits count modulo 1024, so a frame that starts near the top of the window continues at the window's base partway down the picture.

Software sets up the block through an index/data port pair. It first writes a register number to the index port, then writes the value to the data port. The data port also reads back the register that is currently indexed. New settings are held in a staging copy and take effect at the next frame boundary, so one frame never mixes two configurations. Besides the address, the block outputs the scanline number within the current row and flags for the horizontally and vertically displayed areas.

Top module: `cellrow_scan_gen`

## Requirements
- R1: Asserting `reg_wr` with `reg_port`=0 loads the index from `reg_wdata[4:0]`. Asserting `reg_wr` with `reg_port`=1 writes `reg_wdata` to the indexed register. `reg_rdata` shows the indexed register with its unimplemented bits as 0. Register 1 is cells per row (8 bits). Register 6 is displayed rows (8 bits). Register 9 is scanlines per row minus one (5 bits). Register 12 is start address bits 13:8 (6 bits). Register 13 is start address bits 7:0.
- R2: Every other index reads back 0, and writing it changes neither any register nor any output.
- R3: After reset the index is 0. The registers hold cells 40, rows 25, scanlines-minus-one 4 and start 0x2800. The outputs show `mem_addr`=0x2800, `row_line`=0, and both active flags are 1.
- R4: `row_line` counts from 0 up to the scanlines-minus-one value and returns to 0 when a new row begins. It advances once per line of C+H_BLANK cell times.
- R5: During a line, the address in cell time c of row r is the row's start plus c. The same sequence repeats on every scanline of the row.
- R6: After the last scanline of a row, the row start advances by the cells-per-row count C.
- R7: The low 10 bits of `mem_addr` wrap modulo 1024. Bits 13:10 always equal bits 13:10 of the live start address.
- R8: `h_active` is 1 exactly for cell times 0 to C-1 of each line. Each line lasts C+H_BLANK cell times (default H_BLANK=8).
- R9: `v_active` is 1 exactly for rows 0 to R-1. A frame has R+V_BLANK rows (default V_BLANK=2).
- R10: Register writes take effect at the first cell time of the next frame. The first row of every frame starts at the start address in effect for that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register port write strobe |
| reg_port | input | 1 | 0 selects the index port, 1 selects the data port |
| reg_wdata | input | 8 | Write data for the register port |
| reg_rdata | output | 8 | Value of the currently indexed register |
| mem_addr | output | ADDR_W (14) | Cell fetch address |
| row_line | output | LINE_W (5) | Scanline number within the current row |
| h_active | output | 1 | Cell time is inside the displayed width |
| v_active | output | 1 | Row is inside the displayed height |

## Verification
A bad row-start register misplaces every address of a row from its first cell time, and the error stays until the next frame reload. A bad scanline or row count first appears as a wrong `row_line` or `v_active` at the following line boundary. A configuration that is latched early shows up within one line of the write, before the frame boundary where it belongs. The bench compares every output on every cell time of four consecutive frames under three configurations, one of which starts 4 bytes below the top of its window. Each of these faults is therefore caught on the first cell time where it shows.

// File: rtl/cellrow_pkg.sv
package cellrow_pkg;

   localparam int IDX_W = 5;

   localparam logic [IDX_W-1:0] RIX_CELLS    = 5'd1;
   localparam logic [IDX_W-1:0] RIX_ROWS     = 5'd6;
   localparam logic [IDX_W-1:0] RIX_LINES    = 5'd9;
   localparam logic [IDX_W-1:0] RIX_START_HI = 5'd12;
   localparam logic [IDX_W-1:0] RIX_START_LO = 5'd13;

   typedef enum logic {
      PORT_INDEX = 1'b0,
      PORT_DATA  = 1'b1
   } port_sel_e;

   function automatic logic idx_known(input logic [IDX_W-1:0] ix);
      return (ix == RIX_CELLS) || (ix == RIX_ROWS) || (ix == RIX_LINES) ||
             (ix == RIX_START_HI) || (ix == RIX_START_LO);
   endfunction

endpackage

// File: rtl/cellrow_regs.sv
module cellrow_regs
   import cellrow_pkg::*;
#(
   parameter int ADDR_W    = 14,
   parameter int LINE_W    = 5,
   parameter int CNT_W     = 8,
   parameter int DEF_CELLS = 40,
   parameter int DEF_ROWS  = 25,
   parameter int DEF_LINES = 4,
   parameter int DEF_START = 'h2800
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              port_sel,
   input  logic [7:0]        wdata,
   input  logic              frame_end,
   output logic [7:0]        rdata,
   output logic [IDX_W-1:0]  cur_idx,
   output logic [ADDR_W-1:0] sh_start,
   output logic [CNT_W-1:0]  lv_cells,
   output logic [CNT_W-1:0]  lv_rows,
   output logic [LINE_W-1:0] lv_lines,
   output logic [ADDR_W-1:0] lv_start
);

   localparam int HI_W = ADDR_W - 8;

   logic [IDX_W-1:0]  idx_q;
   logic [CNT_W-1:0]  sh_cells;
   logic [CNT_W-1:0]  sh_rows;
   logic [LINE_W-1:0] sh_lines;
   logic              wr_idx;
   logic              wr_dat;

   assign wr_idx = wr_en && (port_sel == PORT_INDEX);
   assign wr_dat = wr_en && (port_sel == PORT_DATA);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q    <= '0;
         sh_cells <= CNT_W'(DEF_CELLS);
         sh_rows  <= CNT_W'(DEF_ROWS);
         sh_lines <= LINE_W'(DEF_LINES);
         sh_start <= ADDR_W'(DEF_START);
      end else begin
         if (wr_idx) begin
            idx_q <= wdata[IDX_W-1:0];
         end
         if (wr_dat) begin
            case (idx_q)
               RIX_CELLS:    sh_cells <= wdata[CNT_W-1:0];
               RIX_ROWS:     sh_rows  <= wdata[CNT_W-1:0];
               RIX_LINES:    sh_lines <= wdata[LINE_W-1:0];
               RIX_START_HI: sh_start[ADDR_W-1:8] <= wdata[HI_W-1:0];
               RIX_START_LO: sh_start[7:0] <= wdata;
               default: ;
            endcase
         end
      end
   end

   // live copy follows the staging copy only at the frame boundary
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lv_cells <= CNT_W'(DEF_CELLS);
         lv_rows  <= CNT_W'(DEF_ROWS);
         lv_lines <= LINE_W'(DEF_LINES);
         lv_start <= ADDR_W'(DEF_START);
      end else if (frame_end) begin
         lv_cells <= sh_cells;
         lv_rows  <= sh_rows;
         lv_lines <= sh_lines;
         lv_start <= sh_start;
      end
   end

   always_comb begin
      rdata = '0;
      case (idx_q)
         RIX_CELLS:    rdata = 8'(sh_cells);
         RIX_ROWS:     rdata = 8'(sh_rows);
         RIX_LINES:    rdata = 8'(sh_lines);
         RIX_START_HI: rdata = 8'(sh_start[ADDR_W-1:8]);
         RIX_START_LO: rdata = sh_start[7:0];
         default:      rdata = '0;
      endcase
   end

   assign cur_idx = idx_q;

endmodule

// File: rtl/cellrow_timing.sv
module cellrow_timing #(
   parameter int CNT_W   = 8,
   parameter int LINE_W  = 5,
   parameter int H_BLANK = 8,
   parameter int V_BLANK = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  lv_cells,
   input  logic [CNT_W-1:0]  lv_rows,
   input  logic [LINE_W-1:0] lv_lines,
   output logic [CNT_W:0]    col,
   output logic [LINE_W-1:0] line,
   output logic              row_end,
   output logic              frame_end,
   output logic              h_active,
   output logic              v_active
);

   localparam int POS_W = CNT_W + 1;

   logic [POS_W-1:0] row_q;
   logic [POS_W-1:0] h_total;
   logic [POS_W-1:0] v_total;
   logic             line_end;

   assign h_total   = {1'b0, lv_cells} + POS_W'(H_BLANK);
   assign v_total   = {1'b0, lv_rows} + POS_W'(V_BLANK);
   assign line_end  = (col == h_total - 1'b1);
   assign row_end   = line_end && (line == lv_lines);
   assign frame_end = row_end && (row_q == v_total - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col   <= '0;
         line  <= '0;
         row_q <= '0;
      end else if (frame_end) begin
         col   <= '0;
         line  <= '0;
         row_q <= '0;
      end else if (row_end) begin
         col   <= '0;
         line  <= '0;
         row_q <= row_q + 1'b1;
      end else if (line_end) begin
         col  <= '0;
         line <= line + 1'b1;
      end else begin
         col <= col + 1'b1;
      end
   end

   assign h_active = (col < {1'b0, lv_cells});
   assign v_active = (row_q < {1'b0, lv_rows});

endmodule

// File: rtl/cellrow_addr.sv
module cellrow_addr #(
   parameter int ADDR_W    = 14,
   parameter int WIN_W     = 10,
   parameter int CNT_W     = 8,
   parameter int DEF_START = 'h2800
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    row_end,
   input  logic                    frame_end,
   input  logic [CNT_W-1:0]        lv_cells,
   input  logic [CNT_W:0]          col,
   input  logic [WIN_W-1:0]        next_base,
   input  logic [ADDR_W-WIN_W-1:0] win_sel,
   output logic [ADDR_W-1:0]       mem_addr
);

   localparam int POS_W = CNT_W + 1;

   logic [WIN_W-1:0] row_base_q;
   logic [WIN_W-1:0] cells_ext;
   logic [WIN_W-1:0] col_ext;

   generate
      if (WIN_W > CNT_W) begin : g_cells_zx
         assign cells_ext = {{(WIN_W-CNT_W){1'b0}}, lv_cells};
      end else begin : g_cells_tr
         assign cells_ext = lv_cells[WIN_W-1:0];
      end
      if (WIN_W > POS_W) begin : g_col_zx
         assign col_ext = {{(WIN_W-POS_W){1'b0}}, col};
      end else begin : g_col_tr
         assign col_ext = col[WIN_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_base_q <= WIN_W'(DEF_START);
      end else if (frame_end) begin
         row_base_q <= next_base;
      end else if (row_end) begin
         row_base_q <= row_base_q + cells_ext;
      end
   end

   assign mem_addr = {win_sel, WIN_W'(row_base_q + col_ext)};

endmodule

// File: rtl/cellrow_scan_gen.sv
module cellrow_scan_gen
   import cellrow_pkg::*;
#(
   parameter int ADDR_W    = 14,
   parameter int WIN_W     = 10,
   parameter int LINE_W    = 5,
   parameter int CNT_W     = 8,
   parameter int H_BLANK   = 8,
   parameter int V_BLANK   = 2,
   parameter int DEF_CELLS = 40,
   parameter int DEF_ROWS  = 25,
   parameter int DEF_LINES = 4,
   parameter int DEF_START = 'h2800
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_port,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [LINE_W-1:0] row_line,
   output logic              h_active,
   output logic              v_active
);

   generate
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr
         $error("ADDR_W must lie in 9..16");
      end
      if (WIN_W < 1 || WIN_W >= ADDR_W) begin : g_bad_win
         $error("WIN_W must be below ADDR_W");
      end
      if (LINE_W < 1 || LINE_W > 8 || CNT_W < 1 || CNT_W > 8) begin : g_bad_cnt
         $error("LINE_W and CNT_W must lie in 1..8");
      end
      if (H_BLANK < 1 || H_BLANK > (1 << CNT_W)) begin : g_bad_hb
         $error("H_BLANK out of range");
      end
      if (V_BLANK < 0 || V_BLANK > (1 << CNT_W)) begin : g_bad_vb
         $error("V_BLANK out of range");
      end
   endgenerate

   logic [IDX_W-1:0]  cur_idx;
   logic [ADDR_W-1:0] sh_start;
   logic [CNT_W-1:0]  lv_cells;
   logic [CNT_W-1:0]  lv_rows;
   logic [LINE_W-1:0] lv_lines;
   logic [ADDR_W-1:0] lv_start;
   logic [CNT_W:0]    col;
   logic              row_end;
   logic              frame_end;

   cellrow_regs #(
      .ADDR_W(ADDR_W), .LINE_W(LINE_W), .CNT_W(CNT_W),
      .DEF_CELLS(DEF_CELLS), .DEF_ROWS(DEF_ROWS),
      .DEF_LINES(DEF_LINES), .DEF_START(DEF_START)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_wr), .port_sel(reg_port), .wdata(reg_wdata),
      .frame_end(frame_end), .rdata(reg_rdata), .cur_idx(cur_idx),
      .sh_start(sh_start),
      .lv_cells(lv_cells), .lv_rows(lv_rows), .lv_lines(lv_lines),
      .lv_start(lv_start)
   );

   cellrow_timing #(
      .CNT_W(CNT_W), .LINE_W(LINE_W), .H_BLANK(H_BLANK), .V_BLANK(V_BLANK)
   ) u_timing (
      .clk(clk), .rst_n(rst_n),
      .lv_cells(lv_cells), .lv_rows(lv_rows), .lv_lines(lv_lines),
      .col(col), .line(row_line), .row_end(row_end), .frame_end(frame_end),
      .h_active(h_active), .v_active(v_active)
   );

   cellrow_addr #(
      .ADDR_W(ADDR_W), .WIN_W(WIN_W), .CNT_W(CNT_W), .DEF_START(DEF_START)
   ) u_addr (
      .clk(clk), .rst_n(rst_n),
      .row_end(row_end), .frame_end(frame_end),
      .lv_cells(lv_cells), .col(col),
      .next_base(sh_start[WIN_W-1:0]),
      .win_sel(lv_start[ADDR_W-1:WIN_W]),
      .mem_addr(mem_addr)
   );

endmodule

// File: rtl/cellrow_scan_chk.sv
module cellrow_scan_chk
   import cellrow_pkg::*;
#(
   parameter int ADDR_W = 14,
   parameter int WIN_W  = 10,
   parameter int LINE_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [LINE_W-1:0] row_line,
   input logic              h_active,
   input logic              v_active,
   input logic [7:0]        reg_rdata,
   input logic [IDX_W-1:0]  cur_idx,
   input logic              row_end,
   input logic              frame_end,
   input logic [LINE_W-1:0] lv_lines
);

   // R4: scanline number holds, steps by one, or restarts at zero
   p_line_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (row_line == 0 || row_line == $past(row_line) ||
                        row_line == $past(row_line) + 1'b1));

   // R4: scanline number never passes the programmed last line
   p_line_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      row_line <= lv_lines);

   // R5: consecutive displayed cell times fetch consecutive addresses
   p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && h_active && $past(h_active)) |->
         (mem_addr[WIN_W-1:0] == $past(mem_addr[WIN_W-1:0]) + 1'b1));

   // R7: window bits move only across a frame boundary
   p_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(frame_end)) |->
         (mem_addr[ADDR_W-1:WIN_W] == $past(mem_addr[ADDR_W-1:WIN_W])));

   // R9: vertical flag changes only on a row boundary
   p_vact_row_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(row_end)) |-> (v_active == $past(v_active)));

   // R10: live scanline count changes only at the frame boundary
   p_live_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(frame_end)) |-> (lv_lines == $past(lv_lines)));

   // R2: unknown indices read back zero
   p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !idx_known(cur_idx) |-> (reg_rdata == 8'h00));

endmodule

bind cellrow_scan_gen cellrow_scan_chk #(
   .ADDR_W(ADDR_W), .WIN_W(WIN_W), .LINE_W(LINE_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .row_line(row_line),
   .h_active(h_active), .v_active(v_active), .reg_rdata(reg_rdata),
   .cur_idx(cur_idx), .row_end(row_end), .frame_end(frame_end),
   .lv_lines(lv_lines)
);

// File: tb/cellrow_scan_gen_tb.sv
module cellrow_scan_gen_tb;

   localparam int HB = 8;
   localparam int VB = 2;

   typedef struct {
      int    addr;
      int    line;
      bit    h;
      bit    v;
      string atag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic       reg_port = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic [13:0] mem_addr;
   logic [4:0] row_line;
   logic       h_active;
   logic       v_active;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   bit released = 1'b0;
   exp_t sb[$];

   always #5 clk = ~clk;

   cellrow_scan_gen u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_port(reg_port),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_addr(mem_addr),
      .row_line(row_line), .h_active(h_active), .v_active(v_active)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // driver side: expected outputs for one frame computed from the requirements
   task automatic push_frame(input int start, input int c_n, input int r_n,
                             input int l_m1, input bit later);
      for (int r = 0; r < r_n + VB; r++) begin
         for (int l = 0; l <= l_m1; l++) begin
            for (int c = 0; c < c_n + HB; c++) begin
               exp_t e;
               int lin;
               lin    = (start & 'h3FF) + r * c_n + c;
               e.addr = (start & 'h3C00) | (lin & 'h3FF);
               e.line = l;
               e.h    = (c < c_n);
               e.v    = (r < r_n);
               if (later && r == 0)  e.atag = "R10";
               else if (lin >= 1024) e.atag = "R7";
               else if (r > 0)       e.atag = "R6";
               else                  e.atag = "R5";
               sb.push_back(e);
            end
         end
      end
   endtask

   task automatic reg_write(input bit port, input logic [7:0] val);
      @(negedge clk);
      reg_wr    = 1'b1;
      reg_port  = port;
      reg_wdata = val;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   // monitor: pops one expected item per cell time
   task automatic monitor();
      bit first = 1'b1;
      while (sb.size() > 0) begin
         exp_t e;
         if (!first) @(negedge clk);
         first = 1'b0;
         e = sb.pop_front();
         if (cyc == 0) begin
            check(mem_addr == 14'(e.addr) && row_line == 5'(e.line) &&
                  h_active == e.h && v_active == e.v, "R3 reset outputs",
                  {mem_addr, row_line, h_active, v_active},
                  {14'(e.addr), 5'(e.line), e.h, e.v});
         end else if (row_line != 5'(e.line)) begin
            check(1'b0, "R4 row_line", row_line, e.line);
         end else if (h_active != e.h) begin
            check(1'b0, "R8 h_active", h_active, e.h);
         end else if (v_active != e.v) begin
            check(1'b0, "R9 v_active", v_active, e.v);
         end else begin
            check(mem_addr == 14'(e.addr), {e.atag, " mem_addr"}, mem_addr, e.addr);
         end
         cyc++;
      end
   endtask

   task automatic driver();
      wait (released);
      @(negedge clk);
      check(reg_rdata == 8'h00, "R3 index 0 reads zero", reg_rdata, 0);
      reg_write(1'b0, 8'd12);
      check(reg_rdata == 8'h28, "R3 default start high", reg_rdata, 'h28);
      reg_write(1'b0, 8'd9);
      check(reg_rdata == 8'h04, "R3 default lines", reg_rdata, 4);
      reg_write(1'b0, 8'd1);
      check(reg_rdata == 8'd40, "R3 default cells", reg_rdata, 40);
      reg_write(1'b0, 8'd3);
      reg_write(1'b1, 8'hFF);
      check(reg_rdata == 8'h00, "R2 unused index 3", reg_rdata, 0);
      reg_write(1'b0, 8'd31);
      reg_write(1'b1, 8'h55);
      check(reg_rdata == 8'h00, "R2 unused index 31", reg_rdata, 0);
      // configuration A: 4 cells, 3 rows, 2 lines, start 4 bytes below window top
      reg_write(1'b0, 8'd1);  reg_write(1'b1, 8'd4);
      check(reg_rdata == 8'd4, "R1 cells readback", reg_rdata, 4);
      reg_write(1'b0, 8'd6);  reg_write(1'b1, 8'd3);
      check(reg_rdata == 8'd3, "R1 rows readback", reg_rdata, 3);
      reg_write(1'b0, 8'd9);  reg_write(1'b1, 8'd1);
      check(reg_rdata == 8'd1, "R1 lines readback", reg_rdata, 1);
      reg_write(1'b0, 8'd12); reg_write(1'b1, 8'hEB);
      check(reg_rdata == 8'h2B, "R1 start high keeps 6 bits", reg_rdata, 'h2B);
      reg_write(1'b0, 8'd13); reg_write(1'b1, 8'hFC);
      check(reg_rdata == 8'hFC, "R1 start low readback", reg_rdata, 'hFC);
      // configuration B written in the middle of frame 2 (R10)
      wait (cyc >= 6490);
      reg_write(1'b0, 8'd1);  reg_write(1'b1, 8'd6);
      reg_write(1'b0, 8'd6);  reg_write(1'b1, 8'd2);
      reg_write(1'b0, 8'd9);  reg_write(1'b1, 8'd0);
      reg_write(1'b0, 8'd12); reg_write(1'b1, 8'h10);
      reg_write(1'b0, 8'd13); reg_write(1'b1, 8'h00);
      check(cyc < 6600, "R10 writes inside frame 2", cyc, 6600);
   endtask

   initial begin
      push_frame('h2800, 40, 25, 4, 1'b0);
      push_frame('h2BFC, 4, 3, 1, 1'b1);
      push_frame('h1000, 6, 2, 0, 1'b1);
      push_frame('h1000, 6, 2, 0, 1'b1);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      released = 1'b1;
      fork
         begin
            fork
               monitor();
               driver();
            join
         end
         begin
            repeat (20000) @(posedge clk);
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule